// File: doc/BRIEF.md
# Rotate-left execution unit

This block executes the rotate-left-through-carry instruction of a processor whose accumulator can be 8 or 16 bits wide. A one-cycle start strobe presents an opcode byte, the operand value, the current carry flag, the accumulator-width mode bit and the low byte of the direct-page base register. The block decodes the opcode into one of five addressing forms and rotates the operand and the carry together one place to the left. It produces the result together with new negative, zero and carry flags. No other flag is driven, so the surrounding core keeps all other status bits as they were.

For the core's sequencer, the block also reports the instruction length in bytes and the total execution time in clock cycles. The cycle count is a base count per addressing form, plus penalties for 16-bit mode and for a direct-page base that is not page-aligned. The block then holds busy for exactly that many cycles and pulses done on the last one. Operand fetch, address generation and the memory bus belong to other blocks. An opcode outside the five recognised ones raises an illegal indication and starts no execution.

Top module: `rotl_exec_unit`

## Requirements
- R1: Recognised opcodes and lengths: 0x2A accumulator form 1 byte, 0x26 direct-page form 2 bytes, 0x36 direct-page-indexed form 2 bytes, 0x2E absolute form 3 bytes, 0x3E absolute-indexed form 3 bytes; length_o shows the length from the cycle after an accepted start.
- R2: With wide_i=0, result bits 7:0 are {operand[6:0], carry_i}, result bits 15:8 equal operand bits 15:8 unchanged, and flag_c_o is operand bit 7.
- R3: With wide_i=1, the result is {operand[14:0], carry_i} and flag_c_o is operand bit 15.
- R4: flag_n_o is result bit 7 when wide_i=0 and result bit 15 when wide_i=1.
- R5: flag_z_o is 1 exactly when the result is zero at the active width; with wide_i=0 only bits 7:0 count, and bits 15:8 are ignored.
- R6: Base cycle counts with wide_i=0 and a zero direct-page low byte: 0x2A 2, 0x26 5, 0x36 6, 0x2E 6, 0x3E 7.
- R7: With wide_i=1, every form except 0x2A takes two cycles more than its base count; 0x2A stays at 2.
- R8: In the 0x26 and 0x36 forms, one more cycle is added when dp_low_i is nonzero; the other forms ignore dp_low_i. The penalties add up (0x36 with wide_i=1 and nonzero dp_low_i takes 9).
- R9: After an accepted start of a recognised opcode, busy_o is high for exactly cycles_o consecutive cycles, starting in the next cycle. done_o is high only in the last of those cycles, and result and flags are valid there.
- R10: For any other opcode, illegal_o is 1 from the cycle after start; busy_o and done_o stay 0, and the result, flags, length_o and cycles_o read 0.
- R11: A start strobe while busy_o is high is ignored: the running count, the result and the flags are not changed.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle strobe that latches the inputs when idle |
| opcode_i | input | 8 | Instruction opcode byte |
| operand_i | input | 16 | Value to rotate |
| carry_i | input | 1 | Current carry flag |
| wide_i | input | 1 | Accumulator width: 0 = 8-bit, 1 = 16-bit |
| dp_low_i | input | 8 | Low byte of the direct-page base register |
| result_o | output | 16 | Rotated value |
| flag_n_o | output | 1 | New negative flag |
| flag_z_o | output | 1 | New zero flag |
| flag_c_o | output | 1 | New carry flag |
| length_o | output | 2 | Instruction length in bytes |
| cycles_o | output | 4 | Total execution cycles |
| busy_o | output | 1 | Execution in progress |
| done_o | output | 1 | Last execution cycle |
| illegal_o | output | 1 | Last started opcode was not recognised |

## Verification
The narrow rotation is swept over every low-byte value with both carry values and a changing upper byte. This separates a 9-bit rotation from a 17-bit one and shows whether the upper byte passes through or takes part in the zero flag. The 16-bit rotation is tried with walking and mixed patterns, including values whose only set bit is the top bit, which expose carry-out and zero-flag errors. The timing is swept over all five opcodes, both widths and zero versus nonzero direct-page low bytes, so each penalty is seen alone and in combination. All 251 unrecognised opcodes are applied, and a start pulse in the middle of a run checks that the running execution is not disturbed.

// File: rtl/rotl_pkg.sv
package rotl_pkg;

  localparam int DATA_W   = 16;
  localparam int NARROW_W = 8;
  localparam int OPC_W    = 8;
  localparam int DPL_W    = 8;
  localparam int LEN_W    = 2;
  localparam int CYC_W    = 4;

  typedef enum logic [2:0] {
    AM_ACC  = 3'd0,
    AM_DP   = 3'd1,
    AM_DPX  = 3'd2,
    AM_ABS  = 3'd3,
    AM_ABSX = 3'd4
  } addr_mode_e;

  localparam logic [OPC_W-1:0] OPC_ACC  = 8'h2A;
  localparam logic [OPC_W-1:0] OPC_DP   = 8'h26;
  localparam logic [OPC_W-1:0] OPC_DPX  = 8'h36;
  localparam logic [OPC_W-1:0] OPC_ABS  = 8'h2E;
  localparam logic [OPC_W-1:0] OPC_ABSX = 8'h3E;

endpackage

// File: rtl/rotl_rst_sync.sv
module rotl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rotl_decode.sv
module rotl_decode
  import rotl_pkg::*;
#(
  parameter int OPC_W_P = OPC_W,
  parameter int LEN_W_P = LEN_W
) (
  input  logic [OPC_W_P-1:0] opcode,
  output logic               legal,
  output addr_mode_e         mode,
  output logic [LEN_W_P-1:0] length
);

  always_comb begin
    legal = 1'b1;
    mode  = AM_ACC;
    unique case (opcode)
      OPC_ACC:  mode = AM_ACC;
      OPC_DP:   mode = AM_DP;
      OPC_DPX:  mode = AM_DPX;
      OPC_ABS:  mode = AM_ABS;
      OPC_ABSX: mode = AM_ABSX;
      default:  legal = 1'b0;
    endcase
  end

  always_comb begin
    unique case (mode)
      AM_ACC:         length = LEN_W_P'(1);
      AM_DP, AM_DPX:  length = LEN_W_P'(2);
      default:        length = LEN_W_P'(3);
    endcase
  end

endmodule

// File: rtl/rotl_timing.sv
module rotl_timing
  import rotl_pkg::*;
#(
  parameter int DPL_W_P = DPL_W,
  parameter int CYC_W_P = CYC_W
) (
  input  addr_mode_e         mode,
  input  logic               wide,
  input  logic [DPL_W_P-1:0] dp_low,
  output logic [CYC_W_P-1:0] cycles
);

  logic [CYC_W_P-1:0] base_cyc;
  logic [CYC_W_P-1:0] wide_pen;
  logic [CYC_W_P-1:0] page_pen;
  logic               is_dp_form;

  always_comb begin
    unique case (mode)
      AM_ACC:  base_cyc = CYC_W_P'(2);
      AM_DP:   base_cyc = CYC_W_P'(5);
      AM_DPX:  base_cyc = CYC_W_P'(6);
      AM_ABS:  base_cyc = CYC_W_P'(6);
      default: base_cyc = CYC_W_P'(7);
    endcase
  end

  assign is_dp_form = (mode == AM_DP) || (mode == AM_DPX);

  always_comb begin
    wide_pen = '0;
    page_pen = '0;
    if (wide && (mode != AM_ACC)) begin
      wide_pen = CYC_W_P'(2);
    end
    if (is_dp_form && (|dp_low)) begin
      page_pen = CYC_W_P'(1);
    end
  end

  assign cycles = base_cyc + wide_pen + page_pen;

endmodule

// File: rtl/rotl_datapath.sv
module rotl_datapath #(
  parameter int DATA_W_P   = 16,
  parameter int NARROW_W_P = 8
) (
  input  logic [DATA_W_P-1:0] operand,
  input  logic                carry,
  input  logic                wide,
  output logic [DATA_W_P-1:0] result,
  output logic                neg,
  output logic                zero,
  output logic                carry_out
);

  logic [DATA_W_P-1:0]   full_rot;
  logic [NARROW_W_P-1:0] low_rot;
  logic [DATA_W_P-1:0]   narrow_res;

  assign full_rot = {operand[DATA_W_P-2:0], carry};
  assign low_rot  = {operand[NARROW_W_P-2:0], carry};

  generate
    if (DATA_W_P > NARROW_W_P) begin : g_upper_pass
      assign narrow_res = {operand[DATA_W_P-1:NARROW_W_P], low_rot};
    end else begin : g_no_upper
      assign narrow_res = low_rot;
    end
  endgenerate

  always_comb begin
    if (wide) begin
      result    = full_rot;
      carry_out = operand[DATA_W_P-1];
      neg       = full_rot[DATA_W_P-1];
      zero      = ~|full_rot;
    end else begin
      result    = narrow_res;
      carry_out = operand[NARROW_W_P-1];
      neg       = low_rot[NARROW_W_P-1];
      zero      = ~|low_rot;
    end
  end

endmodule

// File: rtl/rotl_exec_unit.sv
module rotl_exec_unit
  import rotl_pkg::*;
#(
  parameter int DATA_W_P   = DATA_W,
  parameter int NARROW_W_P = NARROW_W,
  parameter int CYC_W      = rotl_pkg::CYC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [OPC_W-1:0]    opcode_i,
  input  logic [DATA_W_P-1:0] operand_i,
  input  logic                carry_i,
  input  logic                wide_i,
  input  logic [DPL_W-1:0]    dp_low_i,
  output logic [DATA_W_P-1:0] result_o,
  output logic                flag_n_o,
  output logic                flag_z_o,
  output logic                flag_c_o,
  output logic [LEN_W-1:0]    length_o,
  output logic [CYC_W-1:0]    cycles_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                illegal_o
);

  logic rst_sync_n;

  rotl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // decode of the incoming instruction
  logic             in_legal;
  addr_mode_e       in_mode;
  logic [LEN_W-1:0] in_len;
  logic [CYC_W-1:0] in_cyc;

  rotl_decode #(.OPC_W_P(OPC_W), .LEN_W_P(LEN_W)) u_dec (
    .opcode (opcode_i),
    .legal  (in_legal),
    .mode   (in_mode),
    .length (in_len)
  );

  rotl_timing #(.DPL_W_P(DPL_W), .CYC_W_P(CYC_W)) u_tim (
    .mode   (in_mode),
    .wide   (wide_i),
    .dp_low (dp_low_i),
    .cycles (in_cyc)
  );

  // latched instruction state
  logic                accept;
  logic [DATA_W_P-1:0] opnd_q;
  logic                carry_q;
  logic                wide_q;
  logic                legal_q;
  logic                issued_q;
  logic [LEN_W-1:0]    len_q, len_d;
  logic [CYC_W-1:0]    cyc_q, cyc_d;

  // sequencer state
  logic                busy_q, busy_d;
  logic [CYC_W-1:0]    cnt_q, cnt_d;

  assign accept = start_i & ~busy_q;
  assign len_d  = in_legal ? in_len : '0;
  assign cyc_d  = in_legal ? in_cyc : '0;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      opnd_q   <= '0;
      carry_q  <= 1'b0;
      wide_q   <= 1'b0;
      legal_q  <= 1'b0;
      issued_q <= 1'b0;
      len_q    <= '0;
      cyc_q    <= '0;
    end else if (accept) begin
      opnd_q   <= operand_i;
      carry_q  <= carry_i;
      wide_q   <= wide_i;
      legal_q  <= in_legal;
      issued_q <= 1'b1;
      len_q    <= len_d;
      cyc_q    <= cyc_d;
    end
  end

  // next-state of the cycle counter
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = in_legal;
      cnt_d  = in_legal ? (in_cyc - CYC_W'(1)) : '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CYC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // rotation on the latched operand
  logic [DATA_W_P-1:0] rot_res;
  logic                rot_n, rot_z, rot_c;

  rotl_datapath #(.DATA_W_P(DATA_W_P), .NARROW_W_P(NARROW_W_P)) u_dp (
    .operand   (opnd_q),
    .carry     (carry_q),
    .wide      (wide_q),
    .result    (rot_res),
    .neg       (rot_n),
    .zero      (rot_z),
    .carry_out (rot_c)
  );

  logic show;
  assign show = issued_q & legal_q;

  assign result_o  = show ? rot_res : '0;
  assign flag_n_o  = show & rot_n;
  assign flag_z_o  = show & rot_z;
  assign flag_c_o  = show & rot_c;
  assign length_o  = len_q;
  assign cycles_o  = cyc_q;
  assign busy_o    = busy_q;
  assign done_o    = busy_q & (cnt_q == '0);
  assign illegal_o = issued_q & ~legal_q;

endmodule

// File: rtl/rotl_exec_chk.sv
module rotl_exec_chk #(
  parameter int DATA_W_P = 16,
  parameter int LEN_W_P  = 2,
  parameter int CYC_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy_o,
  input logic                done_o,
  input logic                illegal_o,
  input logic [LEN_W_P-1:0]  length_o,
  input logic [CYC_W-1:0]    cycles_o,
  input logic [DATA_W_P-1:0] result_o
);

  logic [CYC_W-1:0] run_q;
  logic [CYC_W-1:0] run_inc;

  assign run_inc = run_q + {{(CYC_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (busy_o && !done_o) begin
      run_q <= run_inc;
    end else begin
      run_q <= '0;
    end
  end

  // R9
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_inc == cycles_o));

  // R10
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!busy_o && !done_o));

  // R6
  cycle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (cycles_o >= CYC_W'(2) && cycles_o <= CYC_W'(9)));

  // R1
  length_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (length_o != '0));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(result_o) && $stable(cycles_o)));

endmodule

bind rotl_exec_unit rotl_exec_chk #(
  .DATA_W_P (DATA_W_P),
  .LEN_W_P  (rotl_pkg::LEN_W),
  .CYC_W    (CYC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .illegal_o (illegal_o),
  .length_o  (length_o),
  .cycles_o  (cycles_o),
  .result_o  (result_o)
);

// File: tb/rotl_exec_unit_tb.sv
module rotl_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic [15:0] operand_i = 16'h0000;
  logic        carry_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [7:0]  dp_low_i = 8'h00;
  logic [15:0] result_o;
  logic        flag_n_o, flag_z_o, flag_c_o;
  logic [1:0]  length_o;
  logic [3:0]  cycles_o;
  logic        busy_o, done_o, illegal_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rotl_exec_unit u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .opcode_i (opcode_i),
    .operand_i (operand_i), .carry_i (carry_i), .wide_i (wide_i),
    .dp_low_i (dp_low_i), .result_o (result_o), .flag_n_o (flag_n_o),
    .flag_z_o (flag_z_o), .flag_c_o (flag_c_o), .length_o (length_o),
    .cycles_o (cycles_o), .busy_o (busy_o), .done_o (done_o),
    .illegal_o (illegal_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_legal(input logic [7:0] opc);
    return opc == 8'h2A || opc == 8'h26 || opc == 8'h36 || opc == 8'h2E || opc == 8'h3E;
  endfunction

  function automatic int exp_len(input logic [7:0] opc);
    if (opc == 8'h2A) return 1;
    if (opc == 8'h26 || opc == 8'h36) return 2;
    return 3;
  endfunction

  function automatic int exp_cyc(input logic [7:0] opc, input bit w, input logic [7:0] dp);
    int c;
    case (opc)
      8'h2A: c = 2;
      8'h26: c = 5;
      8'h36: c = 6;
      8'h2E: c = 6;
      default: c = 7;
    endcase
    if (w && opc != 8'h2A) c += 2;
    if ((opc == 8'h26 || opc == 8'h36) && dp != 0) c += 1;
    return c;
  endfunction

  // runs one instruction; intr > 0 pulses a second start in that busy cycle
  task automatic run_op(input logic [7:0] opc, input logic [15:0] opnd, input bit c,
                        input bit w, input logic [7:0] dp, input int intr);
    int cnt, done_at, done_n, ecyc;
    logic [15:0] eres;
    bit ec, en, ez;
    @(negedge clk);
    start_i = 1'b1; opcode_i = opc; operand_i = opnd; carry_i = c;
    wide_i = w; dp_low_i = dp;
    @(negedge clk);
    start_i = 1'b0;
    if (!is_legal(opc)) begin
      chk("R10", "illegal", int'(illegal_o), 1);
      chk("R10", "busy", int'(busy_o), 0);
      chk("R10", "result", int'(result_o), 0);
      chk("R10", "flags", int'({flag_n_o, flag_z_o, flag_c_o}), 0);
      chk("R10", "len/cyc", int'({length_o, cycles_o}), 0);
      @(negedge clk);
      chk("R10", "busy later", int'({busy_o, done_o}), 0);
      return;
    end
    if (w) begin
      eres = {opnd[14:0], c}; ec = opnd[15]; en = eres[15]; ez = (eres == 16'h0);
    end else begin
      eres = {opnd[15:8], opnd[6:0], c}; ec = opnd[7]; en = eres[7]; ez = (eres[7:0] == 8'h0);
    end
    ecyc = exp_cyc(opc, w, dp);
    cnt = 0; done_at = 0; done_n = 0;
    chk("R1", "length", int'(length_o), exp_len(opc));
    chk("R6 R7 R8", "cycles", int'(cycles_o), ecyc);
    chk("R10", "illegal clear", int'(illegal_o), 0);
    while (busy_o && cnt < 20) begin
      cnt++;
      if (done_o) begin
        done_at = cnt; done_n++;
        chk(w ? "R3" : "R2", "result", int'(result_o), int'(eres));
        chk(w ? "R3" : "R2", "carry", int'(flag_c_o), int'(ec));
        chk("R4", "neg", int'(flag_n_o), int'(en));
        chk("R5", "zero", int'(flag_z_o), int'(ez));
      end
      if (intr > 0 && cnt == intr) begin
        start_i = 1'b1; opcode_i = 8'h2A; operand_i = ~opnd; carry_i = ~c; wide_i = ~w;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    chk("R9", "busy cycles", cnt, ecyc);
    chk("R9", "done position", done_at, ecyc);
    chk("R9", "done pulses", done_n, 1);
    if (intr > 0) begin
      chk("R11", "result kept", int'(result_o), int'(eres));
      chk("R11", "cycles kept", int'(cycles_o), ecyc);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "result", int'(result_o), 0);
    chk("R12", "flags", int'({flag_n_o, flag_z_o, flag_c_o}), 0);
    chk("R12", "len/cyc", int'({length_o, cycles_o}), 0);
    chk("R12", "ctl", int'({busy_o, done_o, illegal_o}), 0);

    // R2 R5: narrow rotation sweep, upper byte varies
    for (int i = 0; i < 256; i++) begin
      for (int c = 0; c < 2; c++) begin
        run_op(8'h2A, {8'(i * 37 + 5), 8'(i)}, c[0], 1'b0, 8'h00, 0);
      end
    end
    // R3 R4: wide rotation patterns
    for (int i = 0; i < 16; i++) begin
      for (int c = 0; c < 2; c++) begin
        run_op(8'h2A, 16'h0001 << i, c[0], 1'b1, 8'h00, 0);
        run_op(8'h2E, ~(16'h0001 << i), c[0], 1'b1, 8'h00, 0);
        run_op(8'h3E, 16'(i * 16'h1357 + 16'h8000), c[0], 1'b1, 8'h00, 0);
      end
    end
    // R5 corner zero cases
    run_op(8'h2A, 16'hAB00, 1'b0, 1'b0, 8'h00, 0);
    run_op(8'h2A, 16'h0080, 1'b0, 1'b0, 8'h00, 0);
    run_op(8'h2A, 16'h8000, 1'b0, 1'b1, 8'h00, 0);
    run_op(8'h2A, 16'h0080, 1'b0, 1'b1, 8'h00, 0);

    // R6 R7 R8 timing sweep
    begin
      logic [7:0] ops [5] = '{8'h2A, 8'h26, 8'h36, 8'h2E, 8'h3E};
      logic [7:0] dps [4] = '{8'h00, 8'h01, 8'h80, 8'hFF};
      for (int o = 0; o < 5; o++)
        for (int w = 0; w < 2; w++)
          for (int d = 0; d < 4; d++)
            run_op(ops[o], 16'h5AC3 ^ 16'(o * 257 + d), w[0], w[0], dps[d], 0);
    end
    // R8 combined worst case
    run_op(8'h36, 16'h1234, 1'b1, 1'b1, 8'h40, 0);

    // R11 start pulse while busy
    run_op(8'h3E, 16'hC0DE, 1'b1, 1'b1, 8'h00, 3);
    run_op(8'h36, 16'h00FF, 1'b0, 1'b0, 8'h07, 5);

    // R10 every unrecognised opcode
    for (int o = 0; o < 256; o++) begin
      if (!is_legal(8'(o))) run_op(8'(o), 16'hFFFF, 1'b1, o[0], 8'h11, 0);
    end
    // R10 then R9: recovery after illegal
    run_op(8'h26, 16'h4001, 1'b0, 1'b1, 8'h00, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule